// File: doc/BRIEF.md
# Segmented RAM Chip-Select Decoder

This block turns a 16-bit bus address into chip selects for two 32K x 8 static RAM halves that share every address, data and control line. Only the chip selects differ. The most significant address bit picks the half. The lower half answers from 0x0000 to 0x7FFF, and the upper half answers from 0x8000 to 0xFFFF. Each half is divided into eight 4K segments. Each segment is turned on or off by its own bit in a per-half enable mask, which stands in for a bank of switches. This lets a system leave gaps for ROM and I/O anywhere in the map.

The block also produces an active-low direction signal for the bus transceiver. This signal goes low only when a read lands in an enabled segment of either half. Decoding takes place only while the bus-valid strobe is high and the active-low memory-management gate is held low. The block is purely combinational, so every output follows its inputs in the same cycle.

Top module: `seg_ram_decode`

## Requirements
- R1: `ram_lo_sel_n` is low exactly when `bus_vld` is 1, `mmu_gate_n` is 0, `bus_addr[15]` is 0 and `lo_seg_en[bus_addr[14:12]]` is 1.
- R2: `ram_hi_sel_n` is low exactly when `bus_vld` is 1, `mmu_gate_n` is 0, `bus_addr[15]` is 1 and `hi_seg_en[bus_addr[14:12]]` is 1.
- R3: An access to a segment whose enable bit is 0 leaves both chip selects and `xcvr_dir_n` high.
- R4: While `mmu_gate_n` is 1, all three outputs stay high for every address and mask.
- R5: While `bus_vld` is 0, all three outputs stay high.
- R6: `xcvr_dir_n` is low exactly when `bus_rd` is 1 (1 = read, 0 = write) and either chip select is low, so writes never drive it low.
- R7: The two chip selects are never low at the same time.
- R8: Enable bit i of a mask covers offsets i*0x1000 through i*0x1000+0xFFF of its half. With `hi_seg_en` = 0x60 (bits 5 and 6) and `lo_seg_en` = 0, the decoder selects exactly the window 0xD000 to 0xEFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Access direction, 1 = read, 0 = write |
| bus_vld | input | 1 | Bus cycle valid strobe |
| mmu_gate_n | input | 1 | Active-low memory-management gate |
| lo_seg_en | input | 8 | Segment enables for the lower half |
| hi_seg_en | input | 8 | Segment enables for the upper half |
| ram_lo_sel_n | output | 1 | Active-low chip select, lower RAM |
| ram_hi_sel_n | output | 1 | Active-low chip select, upper RAM |
| xcvr_dir_n | output | 1 | Active-low transceiver direction (read hit) |

## Verification
The assertions assume that every input is at a known 0 or 1 level whenever the outputs settle. They also assume that the masks change only between bus accesses, so that each check sees one consistent set of inputs. The bench meets both assumptions. It drives every input from time zero and changes inputs only at a rising edge, then samples the outputs at the following falling edge, well after the combinational paths have settled. All 16 segment positions are swept with random masks, in both directions, and the 0x1000 segment boundaries are probed at their first and last offsets.

// File: rtl/seg_ram_pkg.sv
package seg_ram_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned SEG_BITS = 3;
  localparam int unsigned NUM_SEG  = 1 << SEG_BITS;

  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;
endpackage

// File: rtl/seg_ram_half_sel.sv
module seg_ram_half_sel
  import seg_ram_pkg::*;
#(
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned SB      = SEG_BITS,
  parameter half_e       HALF    = HALF_LO,
  localparam int unsigned NS     = 1 << SB
) (
  input  logic [AW-1:0] addr_i,
  input  logic          gate_i,
  input  logic [NS-1:0] seg_en_i,
  output logic          sel_n_o
);
  logic          region_low_n;
  logic [SB-1:0] seg_idx;
  logic [NS-1:0] seg_hot;
  logic          seg_hit;

  // The upper half sees the top bit inverted so it claims 0x8000 upward.
  generate
    if (HALF == HALF_HI) begin : g_hi
      assign region_low_n = ~addr_i[AW-1];
    end else begin : g_lo
      assign region_low_n = addr_i[AW-1];
    end
  endgenerate

  assign seg_idx = addr_i[AW-2 -: SB];

  generate
    for (genvar s = 0; s < NS; s++) begin : g_seg
      assign seg_hot[s] = (seg_idx == SB'(s)) & seg_en_i[s];
    end
  endgenerate

  assign seg_hit = |seg_hot;

  always_comb begin
    sel_n_o = ~(gate_i & ~region_low_n & seg_hit);
  end
endmodule

// File: rtl/seg_ram_dir.sv
module seg_ram_dir (
  input  logic rd_i,
  input  logic lo_sel_n_i,
  input  logic hi_sel_n_i,
  output logic dir_n_o
);
  logic any_sel;

  always_comb begin
    any_sel = ~(lo_sel_n_i & hi_sel_n_i);
    dir_n_o = ~(rd_i & any_sel);
  end
endmodule

// File: rtl/seg_ram_decode.sv
module seg_ram_decode
  import seg_ram_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned SB = SEG_BITS,
  localparam int unsigned NS = 1 << SB
) (
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_vld,
  input  logic          mmu_gate_n,
  input  logic [NS-1:0] lo_seg_en,
  input  logic [NS-1:0] hi_seg_en,
  output logic          ram_lo_sel_n,
  output logic          ram_hi_sel_n,
  output logic          xcvr_dir_n
);
  logic dec_gate;

  assign dec_gate = bus_vld & ~mmu_gate_n;

  seg_ram_half_sel #(.AW(AW), .SB(SB), .HALF(HALF_LO)) u_lo (
    .addr_i   (bus_addr),
    .gate_i   (dec_gate),
    .seg_en_i (lo_seg_en),
    .sel_n_o  (ram_lo_sel_n)
  );

  seg_ram_half_sel #(.AW(AW), .SB(SB), .HALF(HALF_HI)) u_hi (
    .addr_i   (bus_addr),
    .gate_i   (dec_gate),
    .seg_en_i (hi_seg_en),
    .sel_n_o  (ram_hi_sel_n)
  );

  seg_ram_dir u_dir (
    .rd_i       (bus_rd),
    .lo_sel_n_i (ram_lo_sel_n),
    .hi_sel_n_i (ram_hi_sel_n),
    .dir_n_o    (xcvr_dir_n)
  );
endmodule

// File: rtl/seg_ram_decode_chk.sv
module seg_ram_decode_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned SB = 3,
  localparam int unsigned NS = 1 << SB
) (
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_vld,
  input logic          mmu_gate_n,
  input logic [NS-1:0] lo_seg_en,
  input logic [NS-1:0] hi_seg_en,
  input logic          ram_lo_sel_n,
  input logic          ram_hi_sel_n,
  input logic          xcvr_dir_n
);
  logic [SB-1:0] seg;
  assign seg = bus_addr[AW-2 -: SB];

  always_comb begin
    // R7
    a_r7_one_half: assert (ram_lo_sel_n | ram_hi_sel_n);
    // R5
    a_r5_idle_quiet: assert (bus_vld | (ram_lo_sel_n & ram_hi_sel_n & xcvr_dir_n));
    // R4
    a_r4_mmu_blocks: assert (!mmu_gate_n | (ram_lo_sel_n & ram_hi_sel_n & xcvr_dir_n));
    // R6
    a_r6_write_dir_high: assert (bus_rd | xcvr_dir_n);
    a_r6_dir_needs_sel: assert (xcvr_dir_n | !(ram_lo_sel_n & ram_hi_sel_n));
    // R1, R3
    a_r1_lo_region: assert (ram_lo_sel_n | (!bus_addr[AW-1] & lo_seg_en[seg]));
    // R2, R3
    a_r2_hi_region: assert (ram_hi_sel_n | (bus_addr[AW-1] & hi_seg_en[seg]));
  end
endmodule

bind seg_ram_decode seg_ram_decode_chk #(.AW(AW), .SB(SB)) u_chk (
  .bus_addr     (bus_addr),
  .bus_rd       (bus_rd),
  .bus_vld      (bus_vld),
  .mmu_gate_n   (mmu_gate_n),
  .lo_seg_en    (lo_seg_en),
  .hi_seg_en    (hi_seg_en),
  .ram_lo_sel_n (ram_lo_sel_n),
  .ram_hi_sel_n (ram_hi_sel_n),
  .xcvr_dir_n   (xcvr_dir_n)
);

// File: tb/test_seg_ram_decode.sv
module test_seg_ram_decode;
  logic        clk;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic        bus_vld;
  logic        mmu_gate_n;
  logic [7:0]  lo_seg_en;
  logic [7:0]  hi_seg_en;
  logic        ram_lo_sel_n;
  logic        ram_hi_sel_n;
  logic        xcvr_dir_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  seg_ram_decode i_seg_ram_decode (
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_vld      (bus_vld),
    .mmu_gate_n   (mmu_gate_n),
    .lo_seg_en    (lo_seg_en),
    .hi_seg_en    (hi_seg_en),
    .ram_lo_sel_n (ram_lo_sel_n),
    .ram_hi_sel_n (ram_hi_sel_n),
    .xcvr_dir_n   (xcvr_dir_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Drive one access at a rising edge; outputs are sampled at the next falling edge.
  task automatic drive(input logic [15:0] a, input logic rd, input logic vld,
                       input logic mm, input logic [7:0] lo, input logic [7:0] hi);
    @(posedge clk);
    bus_addr = a; bus_rd = rd; bus_vld = vld; mmu_gate_n = mm;
    lo_seg_en = lo; hi_seg_en = hi;
    @(negedge clk);
  endtask

  // Expected outputs derived from R1, R2 and R6.
  task automatic check_outs(input string req);
    logic [2:0] s;
    logic       en, exp_lo, exp_hi, exp_dir;
    s       = bus_addr[14:12];
    en      = bus_vld & ~mmu_gate_n;
    exp_lo  = ~(en & ~bus_addr[15] & lo_seg_en[s]);
    exp_hi  = ~(en &  bus_addr[15] & hi_seg_en[s]);
    exp_dir = ~(bus_rd & ~(exp_lo & exp_hi));
    checks++;
    if ({ram_lo_sel_n, ram_hi_sel_n, xcvr_dir_n} !== {exp_lo, exp_hi, exp_dir}) begin
      errors++;
      $display("FAIL %s addr=%h rd=%0b lo/hi/dir actual=%b%b%b expected=%b%b%b",
               req, bus_addr, bus_rd, ram_lo_sel_n, ram_hi_sel_n, xcvr_dir_n,
               exp_lo, exp_hi, exp_dir);
    end
  endtask

  task automatic check_high(input string req);
    checks++;
    if ({ram_lo_sel_n, ram_hi_sel_n, xcvr_dir_n} !== 3'b111) begin
      errors++;
      $display("FAIL %s addr=%h actual=%b%b%b expected=111", req, bus_addr,
               ram_lo_sel_n, ram_hi_sel_n, xcvr_dir_n);
    end
  endtask

  task automatic t_idle_state();
    drive(16'h0000, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF);
    check_high("R5 idle reset state");
    drive(16'hC123, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF);
    check_high("R5 idle upper");
  endtask

  task automatic t_mmu_gate();
    for (int p = 0; p < 16; p++) begin
      drive(16'(p << 12) | 16'h0ABC, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF);
      check_high("R4 gate high");
    end
  endtask

  task automatic t_sweep();
    for (int r = 0; r < 40; r++) begin
      logic [7:0] lo, hi;
      lo = 8'($urandom);
      hi = 8'($urandom);
      for (int p = 0; p < 16; p++) begin
        for (int d = 0; d < 2; d++) begin
          drive(16'(p << 12) | 16'($urandom_range(0, 16'h0FFF)), d[0], 1'b1, 1'b0, lo, hi);
          check_outs(p < 8 ? "R1 R6 R7 lower sweep" : "R2 R6 R7 upper sweep");
        end
      end
    end
  endtask

  task automatic t_single_segment();
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < 16; p++) begin
        drive(16'(p << 12), 1'b1, 1'b1, 1'b0, 8'(1 << i), 8'(1 << i));
        check_outs("R8 R3 first offset");
        drive(16'(p << 12) | 16'h0FFF, 1'b1, 1'b1, 1'b0, 8'(1 << i), 8'(1 << i));
        check_outs("R8 R3 last offset");
      end
    end
  endtask

  task automatic t_disabled();
    drive(16'h3456, 1'b1, 1'b1, 1'b0, 8'hF7, 8'hFF);
    check_high("R3 lower hole");
    drive(16'hB456, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hF7);
    check_high("R3 upper hole write");
  endtask

  task automatic t_window();
    for (int p = 0; p < 16; p++) begin
      logic in_win;
      in_win = (p == 13) || (p == 14);
      drive(16'(p << 12) | 16'h0800, 1'b1, 1'b1, 1'b0, 8'h00, 8'h60);
      checks++;
      if ({ram_lo_sel_n, ram_hi_sel_n, xcvr_dir_n} !== {1'b1, ~in_win, ~in_win}) begin
        errors++;
        $display("FAIL R8 window addr=%h actual=%b%b%b expected=1%b%b", bus_addr,
                 ram_lo_sel_n, ram_hi_sel_n, xcvr_dir_n, ~in_win, ~in_win);
      end
    end
  endtask

  task automatic t_write_dir();
    drive(16'hD000, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF);
    checks++;
    if ({ram_lo_sel_n, ram_hi_sel_n, xcvr_dir_n} !== 3'b101) begin
      errors++;
      $display("FAIL R6 write actual=%b%b%b expected=101",
               ram_lo_sel_n, ram_hi_sel_n, xcvr_dir_n);
    end
  endtask

  initial begin
    bus_addr = '0; bus_rd = 1'b0; bus_vld = 1'b0; mmu_gate_n = 1'b1;
    lo_seg_en = '0; hi_seg_en = '0;
    repeat (2) @(posedge clk);
    t_idle_state();
    t_mmu_gate();
    t_disabled();
    t_write_dir();
    t_window();
    t_single_segment();
    t_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule